// File: doc/BRIEF.md
# Serial DAC Register Front End

This block is the digital front end of a single-channel current-output converter. A host sends 24-bit frames most significant bit first over a three-wire serial link (serial clock, serial data, latch). The frame is committed on a rising latch edge. Its upper byte is then decoded as a command and its lower 16 bits as the payload. The block holds the 16-bit converter code and a 14-bit control word, and drives the control fields straight to the analog side. It also assembles a read-only status word from three fault and activity inputs.

Any register can be read back. One frame names the register, the latch edge turns the serial output driver on, and the following frame (normally a no-op) clocks the value out. A control bit turns on a chained mode. In that mode the bits pushed past the 24-bit shift register leave on the serial output, so several devices can share one data line and one latch. All serial pins are sampled with the system clock `clk`, which must run several times faster than the serial clock.

Top module: `dacSerialFront`

## Requirements
- R1: On each rising edge of `sclk`, `sdin` is shifted into a 24-bit register, MSB first. A committed frame with command byte 0x01 (bits 23:16) loads bits 15:0 into `dacCode`.
- R2: A frame commits only on a rising edge of `latch`, using the last 24 bits shifted in. Serial clock edges shift data whatever the level of `latch` is.
- R3: Command 0x55 loads payload bits 13:0 into the control word, and payload bits 15:14 are dropped. Control bit fields are: `rangeCode` 2:0, `chainEn` 3, `slewEn` 4, `slewStep` 7:5, `slewClk` 11:8, `outEn` 12, `extRes` 13.
- R4: `rangeSel` decodes `rangeCode` as follows: 101 gives 1 (4 to 20 mA), 110 gives 2 (0 to 20 mA), 111 gives 3 (0 to 24 mA), and every other code gives 0.
- R5: With `chainEn` low, a frame that does not have exactly 24 rising `sclk` edges between two latch edges changes no register.
- R6: Command 0x00 (no-op) and any command byte that is not defined leave all registers unchanged.
- R7: Command 0x56 with payload bit 0 set clears the code, the control word and the readback state to zero. With payload bit 0 clear, command 0x56 does nothing.
- R8: Command 0x02 selects a readback source from payload bits 1:0: 00 is status, 01 is the code, 10 is the control word (bits 15:14 read zero), and 11 reads zero. The status word is `ioutFault` in bit 2, `slewActive` in bit 1, `overTemp` in bit 0, and zeros in the upper bits.
- R9: In the frame after a read request, `sdo` presents 8 filler bits and then the 16-bit value, MSB first. `sdo` changes only on falling `sclk` edges, so each bit is stable at the next rising edge.
- R10: `sdoEn` is low after reset. It rises at the latch edge that commits a read request and falls at the next latch edge.
- R11: With `chainEn` set, `sdoEn` is high and `sdo` repeats `sdin` delayed by 24 serial clocks. A frame of 24 or more clocks is accepted and commits its last 24 bits.
- R12: When `rstN` is asserted low (asynchronous), every register and output is cleared to zero and `sdoEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock |
| latch | input | 1 | Frame commit strobe, acts on its rising edge |
| sdin | input | 1 | Serial data in |
| ioutFault | input | 1 | Output fault flag for the status word |
| slewActive | input | 1 | Slewing flag for the status word |
| overTemp | input | 1 | Over-temperature flag for the status word |
| dacCode | output | 16 | Converter code |
| rangeCode | output | 3 | Raw range field |
| rangeSel | output | 2 | Decoded range |
| chainEn | output | 1 | Chained mode enable |
| slewEn | output | 1 | Slew control enable |
| slewStep | output | 3 | Slew step field |
| slewClk | output | 4 | Slew clock field |
| outEn | output | 1 | Output enable |
| extRes | output | 1 | External set resistor select |
| sdo | output | 1 | Serial data out |
| sdoEn | output | 1 | Output driver enable for `sdo` |

## Verification
The embedded assertions check several rules on every clock. The frame counter saturates and clears on each latch edge. Commit actions are mutually exclusive. The code register holds unless it is written, and loads the payload when it is written. A clear empties all registers. The readback shifter moves only on falling serial clock edges. The `sdo` enable changes state only just after a latch edge. Other behaviour needs the bench's frame sequences to show it: the decode of each command byte, rejection of short and long frames, the field positions and range decode, the readback bit order and filler, and the 24-clock delay through the chain.

// File: rtl/dacIfPkg.sv
package dacIfPkg;
  localparam int FRAME_W = 24;
  localparam int PAY_W   = 16;
  localparam int CTRL_W  = 14;
  localparam int STAT_W  = 3;

  localparam logic [7:0] CMD_NOP  = 8'h00;
  localparam logic [7:0] CMD_DATA = 8'h01;
  localparam logic [7:0] CMD_READ = 8'h02;
  localparam logic [7:0] CMD_CTRL = 8'h55;
  localparam logic [7:0] CMD_RST  = 8'h56;

  // control word field positions
  localparam int F_RANGE = 0;
  localparam int F_CHAIN = 3;
  localparam int F_SLEWEN = 4;
  localparam int F_STEP  = 5;
  localparam int F_SCLK  = 8;
  localparam int F_OUTEN = 12;
  localparam int F_EXTR  = 13;

  typedef struct packed {
    logic sclkRise;
    logic sclkFall;
    logic wrData;
    logic wrCtrl;
    logic clrAll;
    logic loadRead;
    logic readActive;
  } strobe_t;
endpackage

// File: rtl/dacSerCtrl.sv
module dacSerCtrl
  import dacIfPkg::*;
#(
  parameter int FRAME_W = dacIfPkg::FRAME_W,
  parameter int PAY_W   = dacIfPkg::PAY_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sclk,
  input  logic                     latch,
  input  logic [FRAME_W-PAY_W-1:0] cmd,
  input  logic                     rstBit,
  input  logic                     chainEn,
  output strobe_t                  stb
);
  localparam int CMD_W = FRAME_W - PAY_W;
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

  logic sclkQ, latchQ;
  logic sclkRise, sclkFall, latchRise;
  logic [CNT_W-1:0] bitCnt;
  logic frameOk, commit, readActive;
  logic wrData, wrCtrl, clrAll, loadRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ  <= 1'b0;
      latchQ <= 1'b0;
    end else begin
      sclkQ  <= sclk;
      latchQ <= latch;
    end
  end

  assign sclkRise  = sclk & ~sclkQ;
  assign sclkFall  = ~sclk & sclkQ;
  assign latchRise = latch & ~latchQ;

  // saturating count of serial edges since the last latch edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      bitCnt <= '0;
    else if (latchRise)
      bitCnt <= '0;
    else if (sclkRise && bitCnt != CNT_SAT)
      bitCnt <= bitCnt + 1'b1;
  end

  assign frameOk  = chainEn ? (bitCnt >= CNT_FULL) : (bitCnt == CNT_FULL);
  assign commit   = latchRise & frameOk;
  assign wrData   = commit & (cmd == CMD_W'(CMD_DATA));
  assign wrCtrl   = commit & (cmd == CMD_W'(CMD_CTRL));
  assign loadRead = commit & (cmd == CMD_W'(CMD_READ));
  assign clrAll   = commit & (cmd == CMD_W'(CMD_RST)) & rstBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      readActive <= 1'b0;
    else if (clrAll)
      readActive <= 1'b0;
    else if (loadRead)
      readActive <= 1'b1;
    else if (latchRise)
      readActive <= 1'b0;
  end

  always_comb begin
    stb.sclkRise   = sclkRise;
    stb.sclkFall   = sclkFall;
    stb.wrData     = wrData;
    stb.wrCtrl     = wrCtrl;
    stb.clrAll     = clrAll;
    stb.loadRead   = loadRead;
    stb.readActive = readActive;
  end

  a_r5_cnt_saturates: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_SAT);
  a_r2_cnt_clears: assert property (@(posedge clk) disable iff (!rstN)
    latchRise |=> bitCnt == '0);
  a_r6_single_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wrData, wrCtrl, clrAll, loadRead}));
  a_r10_rise_on_latch: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readActive) |-> $past(latchRise));
  a_r10_fall_on_latch: assert property (@(posedge clk) disable iff (!rstN)
    $fell(readActive) |-> $past(latchRise));
endmodule

// File: rtl/dacSerData.sv
module dacSerData
  import dacIfPkg::*;
#(
  parameter int FRAME_W = dacIfPkg::FRAME_W,
  parameter int PAY_W   = dacIfPkg::PAY_W,
  parameter int CTRL_W  = dacIfPkg::CTRL_W,
  parameter int STAT_W  = dacIfPkg::STAT_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sdin,
  input  strobe_t                  stb,
  input  logic [STAT_W-1:0]        statusIn,
  output logic [FRAME_W-PAY_W-1:0] cmd,
  output logic                     rstBit,
  output logic [PAY_W-1:0]         dacCode,
  output logic [CTRL_W-1:0]        ctrlWord,
  output logic                     sdo
);
  localparam int CMD_W = FRAME_W - PAY_W;

  logic [FRAME_W-1:0] shiftReg;
  logic [FRAME_W-1:0] outShift;
  logic [PAY_W-1:0]   payload, dataReg, readVal;
  logic [CTRL_W-1:0]  ctrlReg;
  logic               chainBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      shiftReg <= '0;
    else if (stb.sclkRise)
      shiftReg <= {shiftReg[FRAME_W-2:0], sdin};
  end

  assign payload = shiftReg[PAY_W-1:0];
  assign cmd     = shiftReg[FRAME_W-1:PAY_W];
  assign rstBit  = shiftReg[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
      ctrlReg <= '0;
    end else if (stb.clrAll) begin
      dataReg <= '0;
      ctrlReg <= '0;
    end else begin
      if (stb.wrData) dataReg <= payload;
      if (stb.wrCtrl) ctrlReg <= payload[CTRL_W-1:0];
    end
  end

  always_comb begin
    case (payload[1:0])
      2'b00:   readVal = PAY_W'(statusIn);
      2'b01:   readVal = dataReg;
      2'b10:   readVal = PAY_W'(ctrlReg);
      default: readVal = '0;
    endcase
  end

  // readback shifter: filler byte then value, advanced on falling serial edges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      outShift <= '0;
    else if (stb.clrAll)
      outShift <= '0;
    else if (stb.loadRead)
      outShift <= {{CMD_W{1'b0}}, readVal};
    else if (stb.sclkFall && stb.readActive)
      outShift <= {outShift[FRAME_W-2:0], 1'b0};
  end

  // chained pass-through bit, retimed to the falling serial edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      chainBit <= 1'b0;
    else if (stb.clrAll)
      chainBit <= 1'b0;
    else if (stb.sclkFall)
      chainBit <= shiftReg[FRAME_W-1];
  end

  assign sdo      = stb.readActive ? outShift[FRAME_W-1] : chainBit;
  assign dacCode  = dataReg;
  assign ctrlWord = ctrlReg;

  a_r1_data_load: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrData |=> dataReg == $past(shiftReg[PAY_W-1:0]));
  a_r6_data_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.wrData && !stb.clrAll) |=> $stable(dataReg));
  a_r7_clear_all: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrAll |=> (dataReg == '0 && ctrlReg == '0));
  a_r9_shift_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.sclkFall && !stb.loadRead && !stb.clrAll) |=> $stable(outShift));
endmodule

// File: rtl/dacSerialFront.sv
module dacSerialFront
  import dacIfPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclk,
  input  logic        latch,
  input  logic        sdin,
  input  logic        ioutFault,
  input  logic        slewActive,
  input  logic        overTemp,
  output logic [15:0] dacCode,
  output logic [2:0]  rangeCode,
  output logic [1:0]  rangeSel,
  output logic        chainEn,
  output logic        slewEn,
  output logic [2:0]  slewStep,
  output logic [3:0]  slewClk,
  output logic        outEn,
  output logic        extRes,
  output logic        sdo,
  output logic        sdoEn
);
  localparam int CMD_W = FRAME_W - PAY_W;

  strobe_t           stb;
  logic [CMD_W-1:0]  cmd;
  logic              rstBit;
  logic [CTRL_W-1:0] ctrlWord;

  dacSerCtrl #(.FRAME_W(FRAME_W), .PAY_W(PAY_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .latch(latch),
    .cmd(cmd), .rstBit(rstBit), .chainEn(chainEn), .stb(stb)
  );

  dacSerData #(.FRAME_W(FRAME_W), .PAY_W(PAY_W), .CTRL_W(CTRL_W), .STAT_W(STAT_W)) u_data (
    .clk(clk), .rstN(rstN), .sdin(sdin), .stb(stb),
    .statusIn({ioutFault, slewActive, overTemp}),
    .cmd(cmd), .rstBit(rstBit), .dacCode(dacCode), .ctrlWord(ctrlWord), .sdo(sdo)
  );

  assign rangeCode = ctrlWord[F_RANGE +: 3];
  assign chainEn   = ctrlWord[F_CHAIN];
  assign slewEn    = ctrlWord[F_SLEWEN];
  assign slewStep  = ctrlWord[F_STEP +: 3];
  assign slewClk   = ctrlWord[F_SCLK +: 4];
  assign outEn     = ctrlWord[F_OUTEN];
  assign extRes    = ctrlWord[F_EXTR];
  assign sdoEn     = stb.readActive | chainEn;

  always_comb begin
    case (rangeCode)
      3'b101:  rangeSel = 2'd1;
      3'b110:  rangeSel = 2'd2;
      3'b111:  rangeSel = 2'd3;
      default: rangeSel = 2'd0;
    endcase
  end
endmodule

// File: tb/dacSerialFront_test.sv
module dacSerialFront_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0, latch = 1'b0, sdin = 1'b0;
  logic ioutFault = 1'b0, slewActive = 1'b0, overTemp = 1'b0;
  logic [15:0] dacCode;
  logic [2:0] rangeCode, slewStep;
  logic [1:0] rangeSel;
  logic [3:0] slewClk;
  logic chainEn, slewEn, outEn, extRes, sdo, sdoEn;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;
  logic [47:0] cap = '0;

  always #5 clk = ~clk;

  dacSerialFront uut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .latch(latch), .sdin(sdin),
    .ioutFault(ioutFault), .slewActive(slewActive), .overTemp(overTemp),
    .dacCode(dacCode), .rangeCode(rangeCode), .rangeSel(rangeSel),
    .chainEn(chainEn), .slewEn(slewEn), .slewStep(slewStep), .slewClk(slewClk),
    .outEn(outEn), .extRes(extRes), .sdo(sdo), .sdoEn(sdoEn)
  );

  // frame word, expected code, expected control word, expected range select
  localparam logic [55:0] VEC [8] = '{
    {24'h011234, 16'h1234, 14'h0000, 2'd0},
    {24'h550005, 16'h1234, 14'h0005, 2'd1},
    {24'h55F7F7, 16'h1234, 14'h37F7, 2'd3},
    {24'h01FFFF, 16'hFFFF, 14'h37F7, 2'd3},
    {24'h000000, 16'hFFFF, 14'h37F7, 2'd3},
    {24'h42ABCD, 16'hFFFF, 14'h37F7, 2'd3},
    {24'h560000, 16'hFFFF, 14'h37F7, 2'd3},
    {24'h550006, 16'hFFFF, 14'h0006, 2'd2}
  };

  function automatic logic [13:0] ctrlNow();
    return {extRes, outEn, slewClk, slewStep, slewEn, chainEn, rangeCode};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBits(input logic [23:0] w, input int n);
    for (int k = n - 1; k >= 0; k--) begin
      sdin = (k < 24) ? w[k] : 1'b0;
      waitClk(2);
      cap = {cap[46:0], sdo};
      sclk = 1'b1;
      waitClk(2);
      sclk = 1'b0;
      waitClk(2);
    end
  endtask

  task automatic latchPulse();
    latch = 1'b1;
    waitClk(2);
    latch = 1'b0;
    waitClk(2);
  endtask

  task automatic frame(input logic [23:0] w);
    sendBits(w, 24);
    latchPulse();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    waitClk(3);
    // R12: reset state
    check("R12 code", 32'(dacCode), 32'h0);
    check("R12 ctrl", 32'(ctrlNow()), 32'h0);
    check("R12 sdoEn", 32'(sdoEn), 32'h0);
    rstN = 1'b1;
    waitClk(2);

    // table walk: R1 R3 R4 R6 R7
    for (int i = 0; i < 8; i++) begin
      frame(VEC[i][55:32]);
      check($sformatf("R1/R6 vec%0d code", i), 32'(dacCode), 32'(VEC[i][31:16]));
      check($sformatf("R3/R7 vec%0d ctrl", i), 32'(ctrlNow()), 32'(VEC[i][15:2]));
      check($sformatf("R4 vec%0d range", i), 32'(rangeSel), 32'(VEC[i][1:0]));
    end

    // R5: short and long frames are ignored
    frame(24'h01A5C3);
    check("R1 code A5C3", 32'(dacCode), 32'hA5C3);
    sendBits(24'h010055, 23);
    latchPulse();
    check("R5 short frame", 32'(dacCode), 32'hA5C3);
    sendBits(24'h010066, 25);
    latchPulse();
    check("R5 long frame", 32'(dacCode), 32'hA5C3);

    // R2: shifting while latch is high, commit only on a later rise
    latch = 1'b1;
    waitClk(2);
    sendBits(24'h011111, 24);
    latch = 1'b0;
    waitClk(3);
    check("R2 no commit on latch fall", 32'(dacCode), 32'hA5C3);
    latchPulse();
    check("R2 commit on rise", 32'(dacCode), 32'h1111);
    frame(24'h01A5C3);

    // R8 R9 R10: readback of code, control, status and unused address
    frame(24'h020001);
    check("R10 sdoEn after read request", 32'(sdoEn), 32'h1);
    sendBits(24'h000000, 24);
    check("R9 code readback", 32'(cap[15:0]), 32'hA5C3);
    check("R10 sdoEn held during frame", 32'(sdoEn), 32'h1);
    latchPulse();
    check("R10 sdoEn off after next latch", 32'(sdoEn), 32'h0);
    check("R6 nop keeps code", 32'(dacCode), 32'hA5C3);

    frame(24'h020002);
    frame(24'h000000);
    check("R8 control readback", 32'(cap[15:0]), 32'h0006);

    ioutFault = 1'b1; slewActive = 1'b0; overTemp = 1'b1;
    frame(24'h020000);
    frame(24'h000000);
    check("R8 status readback", 32'(cap[15:0]), 32'h0005);
    ioutFault = 1'b0; slewActive = 1'b1; overTemp = 1'b0;
    frame(24'h020000);
    frame(24'h000000);
    check("R8 status slew bit", 32'(cap[15:0]), 32'h0002);

    frame(24'h020003);
    frame(24'h000000);
    check("R8 unused address", 32'(cap[15:0]), 32'h0000);

    // R11: chained mode
    frame(24'h550008);
    check("R11 chainEn set", 32'(chainEn), 32'h1);
    check("R11 sdoEn in chain", 32'(sdoEn), 32'h1);
    sendBits(24'h01CAFE, 24);
    sendBits(24'h01BEEF, 24);
    check("R11 pass-through word", 32'(cap[23:0]), 32'h01CAFE);
    latchPulse();
    check("R11 last word committed", 32'(dacCode), 32'hBEEF);
    frame(24'h550000);
    check("R11 chain off sdoEn", 32'(sdoEn), 32'h0);

    // R7: reset register
    frame(24'h550015);
    frame(24'h560001);
    check("R7 reset clears code", 32'(dacCode), 32'h0);
    check("R7 reset clears ctrl", 32'(ctrlNow()), 32'h0);
    check("R7 reset sdoEn", 32'(sdoEn), 32'h0);

    // R12: asynchronous reset mid-run
    frame(24'h017777);
    #3 rstN = 1'b0;
    #1 check("R12 async clear", 32'(dacCode), 32'h0);
    waitClk(2);
    rstN = 1'b1;
    waitClk(2);
    summary();
  end
endmodule